// File: doc/BRIEF.md
# Bus Master Read Command Selector

This block picks the memory read command that a bus master engine issues for each read burst. It takes the programmed cache line size, counted in 32-bit words, and the length of the requested transfer in bytes. The block first turns the line size into a usable value. A zero becomes a fixed default of 4 words. Any other value is reduced to its highest set bit, which rounds it down to a power of two. The block multiplies that value by four to get the line size in bytes.

The block then compares the transfer length with four effective cache lines. A shorter transfer gets Memory Read Line. A transfer of that size or longer gets Memory Read Multiple. The bus engine raises a request, and the block latches the command and the effective line size one cycle later. It holds both stable until the engine acknowledges them. Changes to the line size register or the length during a burst therefore cannot alter a command that has already been issued.

Top module: `rd_cmd_sel`

## Requirements
- R1: After reset, valid_o is 0, cmd_o is 4'b0000 and line_bytes_o is 0.
- R2: A line size input of 0 gives an effective line size of 16 bytes (4 words).
- R3: A nonzero line size input is rounded down to its highest set bit. line_bytes_o is 4 times that power of two (for example, 8'hFF gives 512 and 8'h06 gives 16).
- R4: A length below 4 times line_bytes_o gives cmd_o = 4'b1110 (Memory Read Line).
- R5: A length of exactly 4 times line_bytes_o, or more, gives cmd_o = 4'b1100 (Memory Read Multiple).
- R6: When req_i is high while valid_o is low, valid_o goes high on the next clock edge, with cmd_o and line_bytes_o computed from that cycle's inputs.
- R7: While valid_o is high and ack_i is low, cmd_o and line_bytes_o hold their values. Changes to cls_i and len_i have no effect on them.
- R8: ack_i high while valid_o is high clears valid_o on the next edge. req_i while valid_o is high is ignored.
- R9: The comparison uses all 16 bits of len_i, with no truncation of high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cls_i | input | 8 | Programmed cache line size in 32-bit words |
| len_i | input | 16 | Requested read length in bytes |
| req_i | input | 1 | Request to select a command |
| ack_i | input | 1 | Engine has taken the command |
| cmd_o | output | 4 | Selected bus read command |
| line_bytes_o | output | 10 | Effective cache line size in bytes |
| valid_o | output | 1 | Command and line size are valid |

## Verification
A wrong normalisation shows up one cycle after a request: line_bytes_o is not a power of two, or it does not match the highest set bit of cls_i. A wrong threshold shows up in the same cycle: cmd_o flips on lengths exactly at, or just below, four lines. Capture and hold faults show up while valid_o is high. In that window cmd_o or line_bytes_o moves after cls_i or len_i is changed, or valid_o fails to fall in the cycle after ack_i. Lengths with only high bits set expose a comparison that drops the upper bits of len_i.

// File: rtl/rd_cmd_pkg.sv
package rd_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_NONE = 4'b0000,
    CMD_MRM  = 4'b1100,
    CMD_MRL  = 4'b1110
  } rd_cmd_e;

  localparam int unsigned LINES_THRESH_LOG2 = 2;  // four lines
endpackage

// File: rtl/cls_norm.sv
module cls_norm #(
  parameter int unsigned CLS_W     = 8,
  parameter int unsigned DEF_WORDS = 4
) (
  input  logic [CLS_W-1:0] cls_i,
  output logic [CLS_W-1:0] words_o
);
  logic [CLS_W:0]   seen;
  logic [CLS_W-1:0] msb;

  assign seen[CLS_W] = 1'b0;

  // seen[i]: any bit at or above i is set; keep only the topmost one
  for (genvar i = 0; i < CLS_W; i++) begin : g_msb
    assign seen[i] = seen[i+1] | cls_i[i];
    assign msb[i]  = cls_i[i] & ~seen[i+1];
  end

  assign words_o = seen[0] ? msb : CLS_W'(DEF_WORDS);
endmodule

// File: rtl/cmd_decide.sv
module cmd_decide
  import rd_cmd_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned LB_W  = 10
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [LB_W-1:0]  line_bytes_i,
  output rd_cmd_e          cmd_o
);
  localparam int unsigned TH_W  = LB_W + LINES_THRESH_LOG2;
  localparam int unsigned CMP_W = (LEN_W > TH_W) ? LEN_W : TH_W;

  logic [CMP_W-1:0] thresh;
  logic [CMP_W-1:0] len_ext;

  assign thresh  = CMP_W'({line_bytes_i, {LINES_THRESH_LOG2{1'b0}}});
  assign len_ext = CMP_W'(len_i);
  assign cmd_o   = (len_ext >= thresh) ? CMD_MRM : CMD_MRL;
endmodule

// File: rtl/rd_cmd_sel.sv
module rd_cmd_sel
  import rd_cmd_pkg::*;
#(
  parameter int unsigned CLS_W     = 8,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned DEF_WORDS = 4,
  localparam int unsigned LB_W     = CLS_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CLS_W-1:0] cls_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             req_i,
  input  logic             ack_i,
  output logic [3:0]       cmd_o,
  output logic [LB_W-1:0]  line_bytes_o,
  output logic             valid_o
);
  logic [CLS_W-1:0] words;
  logic [LB_W-1:0]  line_d;
  rd_cmd_e          cmd_d;

  cls_norm #(.CLS_W(CLS_W), .DEF_WORDS(DEF_WORDS)) u_norm (
    .cls_i   (cls_i),
    .words_o (words)
  );

  assign line_d = {words, 2'b00};

  cmd_decide #(.LEN_W(LEN_W), .LB_W(LB_W)) u_decide (
    .len_i        (len_i),
    .line_bytes_i (line_d),
    .cmd_o        (cmd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      cmd_o        <= CMD_NONE;
      line_bytes_o <= '0;
    end else if (!valid_o && req_i) begin
      valid_o      <= 1'b1;
      cmd_o        <= cmd_d;
      line_bytes_o <= line_d;
    end else if (valid_o && ack_i) begin
      valid_o      <= 1'b0;
    end
  end
endmodule

// File: rtl/rd_cmd_sel_chk.sv
module rd_cmd_sel_chk #(
  parameter int unsigned CLS_W = 8,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned LB_W  = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LEN_W-1:0] len_i,
  input logic             req_i,
  input logic             ack_i,
  input logic [3:0]       cmd_o,
  input logic [LB_W-1:0]  line_bytes_o,
  input logic             valid_o
);
  localparam int unsigned CMP_W = (LEN_W > LB_W + 2) ? LEN_W : LB_W + 2;

  logic [LEN_W-1:0] len_cap;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                len_cap <= '0;
    else if (!valid_o && req_i) len_cap <= len_i;
  end

  a_r6_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && req_i) |=> valid_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ack_i) |=> (valid_o && $stable(cmd_o) && $stable(line_bytes_o)));

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ack_i) |=> !valid_o);

  a_r3_pow2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(line_bytes_o) == 1 && line_bytes_o[1:0] == 2'b00));

  a_r4_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cmd_o == 4'b1110) |-> (CMP_W'(len_cap) < CMP_W'({line_bytes_o, 2'b00})));

  a_r5_multi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cmd_o == 4'b1100) |-> (CMP_W'(len_cap) >= CMP_W'({line_bytes_o, 2'b00})));

  a_r5_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cmd_o == 4'b1100 || cmd_o == 4'b1110));
endmodule

bind rd_cmd_sel rd_cmd_sel_chk #(.CLS_W(CLS_W), .LEN_W(LEN_W), .LB_W(LB_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .len_i        (len_i),
  .req_i        (req_i),
  .ack_i        (ack_i),
  .cmd_o        (cmd_o),
  .line_bytes_o (line_bytes_o),
  .valid_o      (valid_o)
);

// File: tb/rd_cmd_sel_bench.sv
module rd_cmd_sel_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  cls_i = '0;
  logic [15:0] len_i = '0;
  logic        req_i = 1'b0;
  logic        ack_i = 1'b0;
  logic [3:0]  cmd_o;
  logic [9:0]  line_bytes_o;
  logic        valid_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  rd_cmd_sel u_rd_cmd_sel (
    .clk_i, .rst_ni, .cls_i, .len_i, .req_i, .ack_i,
    .cmd_o, .line_bytes_o, .valid_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_line(input logic [7:0] c);
    logic [7:0] w;
    w = 8'd4;
    for (int i = 0; i < 8; i++) if (c[i]) w = 8'(1 << i);
    return {w, 2'b00};
  endfunction

  function automatic logic [3:0] exp_cmd(input logic [7:0] c, input logic [15:0] l);
    return (32'(l) >= 32'(exp_line(c)) * 4) ? 4'b1100 : 4'b1110;
  endfunction

  // Issue, hold with disturbed inputs, acknowledge
  task automatic burst(input string req, input logic [7:0] c, input logic [15:0] l);
    logic [3:0] ec;
    logic [9:0] el;
    ec = exp_cmd(c, l);
    el = exp_line(c);
    @(negedge clk_i);
    cls_i = c; len_i = l; req_i = 1'b1;
    @(negedge clk_i);
    check({req, " R6 valid"}, 32'(valid_o), 1);
    check({req, " cmd"}, 32'(cmd_o), 32'(ec));
    check({req, " line"}, 32'(line_bytes_o), 32'(el));
    cls_i = ~c; len_i = ~l;  // R7, R8: disturbance with req still high
    @(negedge clk_i);
    @(negedge clk_i);
    check("R7 cmd hold", 32'(cmd_o), 32'(ec));
    check("R7 line hold", 32'(line_bytes_o), 32'(el));
    check("R8 req ignored while valid", 32'(valid_o), 1);
    req_i = 1'b0; ack_i = 1'b1;
    @(negedge clk_i);
    check("R8 valid cleared", 32'(valid_o), 0);
    ack_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 valid", 32'(valid_o), 0);
    check("R1 cmd", 32'(cmd_o), 0);
    check("R1 line", 32'(line_bytes_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_default();
    burst("R2 zero short", 8'h00, 16'd63);
    burst("R2 zero long", 8'h00, 16'd64);
  endtask

  task automatic t_round();
    burst("R3 ff", 8'hFF, 16'd2047);
    burst("R3 06", 8'h06, 16'd64);
    burst("R3 05", 8'h05, 16'd63);
  endtask

  task automatic t_thresh();
    burst("R4 below", 8'h08, 16'd127);
    burst("R5 equal", 8'h08, 16'd128);
    burst("R5 max", 8'h80, 16'hFFFF);
  endtask

  task automatic t_wide();
    burst("R9 high bit", 8'h80, 16'h8000);
    burst("R9 high bits", 8'h80, 16'h1000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_default();
        t_round();
        t_thresh();
        t_wide();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule